// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block brings a serially programmed integer-N frequency synthesizer out of power-up. Three 24-bit configuration words are offered on parallel input ports: the reference-divider word, the control word and the feedback-divider word. The block shifts each one out over a three-wire link made of a serial clock, a serial data line and a latch strobe. It always sends them in the same order. Between the control word and the feedback-divider word it holds off for a settling interval. This gives the oscillator bias currents time to settle, so that the synthesizer can later lock.

The serial clock comes from the system clock through an even divider. The settling interval is counted in system-clock cycles and set by a parameter. Its default is 10 ms at a 50 MHz system clock. A shorter interval, such as the one a smaller decoupling capacitor permits, only needs a different parameter value. The sequence starts by itself when reset is released. When it is finished, a start pulse runs it again.

Top module: `synth_init_seq`

## Requirements
- R1: While reset is high, ser_clk, ser_data, ser_le and done are all low.
- R2: Releasing reset starts a sequence without any start pulse.
- R3: The words are sent in a fixed order: ref_word first, then ctl_word, then fb_word. Each is captured from its port when its own shifting begins.
- R4: Each word is sent as exactly 24 bits, most significant bit first. The receiver samples each bit on the rising edge of ser_clk.
- R5: While a word is shifting, ser_clk has a period of CLK_DIV system cycles and stays high for CLK_DIV/2 of them.
- R6: ser_data changes only in a cycle where ser_clk is low and was already low in the previous cycle.
- R7: ser_le stays low while bits are shifting. After the last bit it goes high for exactly CLK_DIV system cycles with ser_clk low. It is then low again before the next word starts.
- R8: The first ser_clk rise of fb_word comes at least SETTLE_CYCLES system cycles after ser_le rises for ctl_word.
- R9: done rises once the fb_word latch pulse has ended. It then stays high with the serial lines idle until a start pulse arrives.
- R10: A start pulse while done is high clears done and runs the whole three-word sequence again.
- R11: Start pulses during a running sequence are ignored. The sequence still sends exactly three words, and no further words follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a sequence |
| start | input | 1 | Request to rerun the sequence; acted on only while done is high |
| ref_word | input | 24 | Reference-divider configuration word |
| ctl_word | input | 24 | Control configuration word |
| fb_word | input | 24 | Feedback-divider configuration word |
| ser_clk | output | 1 | Serial clock; the receiver samples data on its rising edge |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_le | output | 1 | Latch strobe; high after the last bit of each word |
| done | output | 1 | High once the full sequence has been sent |

## Verification
Distinct word values are used, so a swap in the order or a repeated word shows up at once. All-ones and all-zeros words show whether bits are dropped or stuck at one level. Alternating bit patterns show an off-by-one shift or a reversed bit order. A passive monitor rebuilds each word from the serial lines and times the edges. Runs started by reset release and by a start pulse are compared, and a run with start pulses injected mid-sequence separates a correct hold-off from a restart or an extra word.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;

  // Top-level ordering of the three writes and the hold-off between them
  typedef enum logic [2:0] {
    SQ_LD_REF,
    SQ_WT_REF,
    SQ_LD_CTL,
    SQ_WT_CTL,
    SQ_SETTLE,
    SQ_LD_FB,
    SQ_WT_FB,
    SQ_DONE
  } seq_state_t;

  // Phases of one serial word transfer
  typedef enum logic [1:0] {
    SH_IDLE,
    SH_DATA,
    SH_LATCH,
    SH_GAP
  } sh_phase_t;

endpackage

// File: rtl/slot_timer.sv
// Counts system cycles inside one serial bit slot of CLK_DIV cycles.
module slot_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  output logic [$clog2(CLK_DIV)-1:0] pos,
  output logic                       mid,
  output logic                       last
);
  localparam int DW   = $clog2(CLK_DIV);
  localparam int HALF = CLK_DIV / 2;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos <= '0;
    end else if (pos == DW'(CLK_DIV - 1)) begin
      pos <= '0;
    end else begin
      pos <= pos + DW'(1);
    end
  end

  assign mid  = (pos == DW'(HALF - 1));
  assign last = (pos == DW'(CLK_DIV - 1));

  // Slot position never leaves its range (R5)
  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    pos <= DW'(CLK_DIV - 1));

endmodule

// File: rtl/ser_word_tx.sv
// Shifts one word out MSB first, then strobes the latch line for one slot
// and leaves one idle slot before reporting completion.
module ser_word_tx
  import synth_seq_pkg::*;
#(
  parameter int W       = 24,
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         sdata,
  output logic         sle,
  output logic         idle,
  output logic         fin
);
  localparam int DW = $clog2(CLK_DIV);
  localparam int BW = $clog2(W);

  sh_phase_t       phase;
  logic [W-1:0]    sreg;
  logic [BW-1:0]   bitn;
  logic [DW-1:0]   pos;
  logic            mid;
  logic            last;

  initial begin
    assert (CLK_DIV >= 4 && (CLK_DIV % 2) == 0)
      else $error("CLK_DIV must be even and at least 4");
  end

  slot_timer #(.CLK_DIV(CLK_DIV)) u_slot (
    .clk  (clk),
    .rst  (rst),
    .run  (phase != SH_IDLE),
    .pos  (pos),
    .mid  (mid),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= SH_IDLE;
      sreg  <= '0;
      bitn  <= '0;
      sclk  <= 1'b0;
      sdata <= 1'b0;
      sle   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (phase)
        SH_IDLE: begin
          if (go) begin
            phase <= SH_DATA;
            sreg  <= word;
            sdata <= word[W-1];
            bitn  <= '0;
          end
        end
        SH_DATA: begin
          if (pos == '0) sdata <= sreg[W-1];
          if (mid) sclk <= 1'b1;
          if (last) begin
            sclk <= 1'b0;
            sreg <= sreg << 1;
            if (bitn == BW'(W - 1)) begin
              phase <= SH_LATCH;
              sle   <= 1'b1;
            end else begin
              bitn <= bitn + BW'(1);
            end
          end
        end
        SH_LATCH: begin
          if (last) begin
            sle   <= 1'b0;
            phase <= SH_GAP;
          end
        end
        SH_GAP: begin
          if (last) begin
            phase <= SH_IDLE;
            sdata <= 1'b0;
            fin   <= 1'b1;
          end
        end
        default: phase <= SH_IDLE;
      endcase
    end
  end

  assign idle = (phase == SH_IDLE);

  // The serial clock is idle while the latch strobe is high (R7)
  assert_le_clk_low_R7: assert property (@(posedge clk) disable iff (rst)
    sle |-> !sclk);

  // The latch strobe lasts longer than one system cycle (R7)
  assert_le_width_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sle) |=> sle);

  // Data moves only inside a low phase of the serial clock (R6)
  assert_data_in_low_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> (!sclk && !$past(sclk)));

  // The serial clock toggles only while bits are shifting (R5)
  assert_clk_only_data_R5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> (phase == SH_DATA));

endmodule

// File: rtl/settle_timer.sv
// Counts the hold-off between the control write and the feedback write.
module settle_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (load) begin
      cnt     <= LOAD_V;
      expired <= 1'b0;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end else if (cnt == CW'(1)) begin
      cnt     <= '0;
      expired <= 1'b1;
    end
  end

  // Once expired, the flag holds until the next load (R8)
  assert_expire_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

  // A fresh load always clears the flag (R8)
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);

endmodule

// File: rtl/synth_init_seq.sv
module synth_init_seq
  import synth_seq_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int CLK_DIV       = 4,
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] fb_word,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le,
  output logic              done
);

  seq_state_t        st;
  logic              go;
  logic [WORD_W-1:0] tx_word;
  logic              tx_idle;
  logic              tx_fin;
  logic              tmr_load;
  logic              tmr_expired;

  ser_word_tx #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .word  (tx_word),
    .sclk  (ser_clk),
    .sdata (ser_data),
    .sle   (ser_le),
    .idle  (tx_idle),
    .fin   (tx_fin)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_LD_REF;
      go       <= 1'b0;
      tx_word  <= '0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
    end else begin
      go       <= 1'b0;
      tmr_load <= 1'b0;
      unique case (st)
        SQ_LD_REF: begin
          go      <= 1'b1;
          tx_word <= ref_word;
          st      <= SQ_WT_REF;
        end
        SQ_WT_REF: if (tx_fin) st <= SQ_LD_CTL;
        SQ_LD_CTL: begin
          go      <= 1'b1;
          tx_word <= ctl_word;
          st      <= SQ_WT_CTL;
        end
        SQ_WT_CTL: begin
          if (tx_fin) begin
            tmr_load <= 1'b1;
            st       <= SQ_SETTLE;
          end
        end
        SQ_SETTLE: if (tmr_expired && !tmr_load) st <= SQ_LD_FB;
        SQ_LD_FB: begin
          go      <= 1'b1;
          tx_word <= fb_word;
          st      <= SQ_WT_FB;
        end
        SQ_WT_FB: begin
          if (tx_fin) begin
            done <= 1'b1;
            st   <= SQ_DONE;
          end
        end
        SQ_DONE: begin
          if (start) begin
            done <= 1'b0;
            st   <= SQ_LD_REF;
          end
        end
        default: st <= SQ_LD_REF;
      endcase
    end
  end

  // The feedback word is never launched before the hold-off has run out (R8)
  assert_fb_after_settle_R8: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_LD_FB) |-> tmr_expired);

  // A new word is only launched into an idle transmitter (R3)
  assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    go |-> tx_idle);

  // With done high, the serial lines are quiet (R9)
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (tx_idle && !ser_clk && !ser_le));

  // A start request inside a running sequence does not raise done (R11)
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (!done && start && !tx_fin) |=> !done);

endmodule

// File: tb/sim_synth_init_seq.sv
`timescale 1ns/1ps
module sim_synth_init_seq;
  localparam int W      = 24;
  localparam int DIV    = 4;
  localparam int HALF   = DIV / 2;
  localparam int SETTLE = 60;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] ref_word = '0;
  logic [W-1:0] ctl_word = '0;
  logic [W-1:0] fb_word  = '0;
  logic         ser_clk, ser_data, ser_le, done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  synth_init_seq #(.WORD_W(W), .CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .ref_word(ref_word), .ctl_word(ctl_word), .fb_word(fb_word),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .done(done)
  );

  // Passive monitor: rebuilds words and times the serial edges
  logic [W-1:0] words [0:31];
  int           nbits_w [0:31];
  int           widx = 0;
  int           cyc = 0;
  logic [W-1:0] sh = '0;
  int           nbits = 0;
  logic         pclk = 1'b0, pdat = 1'b0, ple = 1'b0;
  int           last_rise = 0;
  int           hi_run = 0, le_run = 0;
  int           ctl_le_cyc = 0;
  int           fb_gap = 0;
  int           per_err = 0, dat_err = 0, le_err = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      nbits = 0; pclk = 1'b0; pdat = 1'b0; ple = 1'b0; hi_run = 0; le_run = 0;
    end else begin
      if (ser_data != pdat && (ser_clk || pclk)) dat_err++;
      if (ser_le && ser_clk) le_err++;
      if (ser_le && nbits != 0 && !ple) begin end
      if (ser_clk && !pclk) begin
        sh = {sh[W-2:0], ser_data};
        nbits++;
        if (nbits > 1 && (cyc - last_rise) != DIV) per_err++;
        if (nbits == 1 && widx % 3 == 2) fb_gap = cyc - ctl_le_cyc;
        last_rise = cyc;
      end
      if (ser_clk) hi_run++;
      if (!ser_clk && pclk) begin
        if (hi_run != HALF) per_err++;
        hi_run = 0;
      end
      if (ser_le && !ple) begin
        if (widx < 32) begin
          words[widx]   = sh;
          nbits_w[widx] = nbits;
        end
        if (widx % 3 == 1) ctl_le_cyc = cyc;
        widx++;
        nbits = 0;
      end
      if (ser_le) le_run++;
      if (!ser_le && ple) begin
        if (le_run != DIV) le_err++;
        le_run = 0;
      end
      pclk = ser_clk; pdat = ser_data; ple = ser_le;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Checks the three words of the run beginning at monitor index base
  task automatic check_run(input int base, input logic [W-1:0] r,
                           input logic [W-1:0] c, input logic [W-1:0] f);
    check(widx - base == 3, "R3", "word count", widx - base, 3);
    check(words[base] == r, "R3", "first word is ref", words[base], r);
    check(words[base+1] == c, "R3", "second word is ctl", words[base+1], c);
    check(words[base+2] == f, "R3", "third word is fb", words[base+2], f);
    for (int k = 0; k < 3; k++)
      check(nbits_w[base+k] == W, "R4", "bits per word", nbits_w[base+k], W);
    check(fb_gap >= SETTLE, "R8", "settle gap lower bound", fb_gap, SETTLE);
    check(fb_gap <= SETTLE + 3*DIV + 8, "R8", "settle gap upper bound",
          fb_gap, SETTLE + 3*DIV + 8);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({ser_clk, ser_data, ser_le, done} == 4'b0, "R1", "outputs in reset",
          {ser_clk, ser_data, ser_le, done}, 0);
  endtask

  task automatic t_power_on();
    bit ok;
    int base;
    ref_word = 24'h12_3456; ctl_word = 24'hA5_0F3C; fb_word = 24'h00_C801;
    base = widx;
    @(negedge clk) rst = 1'b0;
    wait_done(ok);
    check(ok, "R2", "sequence runs after reset release", ok, 1);
    check_run(base, ref_word, ctl_word, fb_word);
    check(per_err == 0, "R5", "serial clock period errors", per_err, 0);
    check(dat_err == 0, "R6", "data changes with clock high", dat_err, 0);
    check(le_err == 0, "R7", "latch strobe errors", le_err, 0);
    repeat (50) @(negedge clk);
    check(done && !ser_clk && !ser_le && widx == base + 3, "R9",
          "done holds with idle lines", {done, ser_clk, ser_le}, 3'b100);
  endtask

  task automatic t_restart(input logic [W-1:0] r, input logic [W-1:0] c,
                           input logic [W-1:0] f);
    bit ok;
    int base;
    ref_word = r; ctl_word = c; fb_word = f;
    base = widx;
    pulse_start();
    @(negedge clk);
    check(!done, "R10", "start clears done", done, 0);
    wait_done(ok);
    check(ok, "R10", "restarted sequence completes", ok, 1);
    check_run(base, r, c, f);
  endtask

  task automatic t_ignore_start();
    bit ok;
    int base;
    ref_word = 24'h5A_5A5A; ctl_word = 24'h3C_C3A5; fb_word = 24'h80_0001;
    base = widx;
    pulse_start();
    while (widx < base + 1) @(negedge clk);
    pulse_start();
    while (widx < base + 2) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_start();
    pulse_start();
    wait_done(ok);
    check(ok, "R11", "sequence finishes despite extra starts", ok, 1);
    check_run(base, ref_word, ctl_word, fb_word);
    repeat (300) @(negedge clk);
    check(widx == base + 3 && done, "R11", "no words after done",
          widx - base, 3);
  endtask

  initial begin
    t_reset();
    t_power_on();
    t_restart(24'hFF_FFFF, 24'h00_0000, 24'hAA_AAAA);
    t_restart(24'h55_5555, 24'h80_0000, 24'h00_0001);
    t_ignore_start();
    check(per_err == 0 && dat_err == 0 && le_err == 0, "R6",
          "monitor errors over all runs", per_err + dat_err + le_err, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog expired: actual 0x%0h expected 0x%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule